// File: doc/BRIEF.md
# Capture/Compare/PWM Channel

One channel of a counter array. It watches a shared free-running count and one external pin, and holds a 16-bit channel register plus a seven-bit mode word. Independent enable bits in the mode word decide what the channel does. It can latch the count when the pin changes with a chosen polarity. It can raise an event when the count reaches the register value, and it can invert its output pin on each such match. It can also produce a pulse-width modulated output, whose duty cycle comes from the register's low byte and is reloaded from its high byte every period.

The channel emits a one-cycle pulse that sets the event flag, which is kept elsewhere. It also presents the interrupt-enable bit for that flag and drives its output pin. Software loads the channel register one byte at a time. A capture that lands in the same cycle as such a write takes precedence over it.

Top module: `ccp_channel`

## Requirements
- R1: After reset, cc_o is 0, pin_o is 0, flag_set_o is 0 and irq_en_o is 0.
- R2: irq_en_o equals bit 0 of the mode word from the cycle after the mode word is written.
- R3: A write with cc_lo_we_i loads cc_wdata_i into cc_o[7:0], and a write with cc_hi_we_i loads it into cc_o[15:8]. Either write takes effect one cycle later and leaves the other byte unchanged.
- R4: With mode bit 5 set, a rising edge on pin_i loads cnt_i into cc_o and pulses flag_set_o for exactly one cycle. Both happen at the third rising clock edge after pin_i changes, because pin_i passes through two synchronizing flops and is then compared with the previous sample.
- R5: Mode bit 4 enables capture on a falling edge of pin_i. With bits 4 and 5 both set, either edge captures. An edge whose polarity is not enabled leaves cc_o unchanged and raises no flag_set_o.
- R6: With mode bits 6 and 3 set, flag_set_o pulses for one cycle when cnt_i first equals cc_o. It does not pulse again while cnt_i stays equal to cc_o.
- R7: With mode bits 6 and 2 set and bit 1 clear, pin_o inverts one cycle after each new equality of cnt_i with cc_o.
- R8: With mode bit 6 clear, equality of cnt_i with cc_o produces no flag_set_o and leaves pin_o unchanged, even when bits 2 and 3 are set.
- R9: With mode bits 6 and 1 set, pin_o is 0 when cnt_i[7:0] is below cc_o[7:0] and 1 otherwise, one cycle later.
- R10: With mode bits 6 and 1 set, when cnt_i[7:0] goes from 8'hFF in one cycle to 8'h00 in the next, cc_o[7:0] is loaded from cc_o[15:8].
- R11: When a capture and a byte write fall on the same clock edge, cc_o takes the captured count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Shared counter value |
| pin_i | input | 1 | External pin, asynchronous |
| mode_we_i | input | 1 | Mode word write strobe |
| mode_wdata_i | input | 7 | Mode word: bit6 compare enable, bit5 rising capture, bit4 falling capture, bit3 match flag, bit2 toggle, bit1 PWM, bit0 interrupt enable |
| cc_lo_we_i | input | 1 | Channel register low byte write strobe |
| cc_hi_we_i | input | 1 | Channel register high byte write strobe |
| cc_wdata_i | input | 8 | Byte write data |
| cc_o | output | 16 | Channel register value |
| flag_set_o | output | 1 | One-cycle event flag set pulse |
| irq_en_o | output | 1 | Interrupt enable for the event flag |
| pin_o | output | 1 | Channel output pin |

## Verification
The bench builds the channel with its default parameters: 8-bit bytes, so a 16-bit count, and two synchronizer stages. These values fix the capture latency at three clock edges, so the bench can land a byte write exactly on the capturing edge. They also keep the PWM period short, so the bench can step the low byte across its FF-to-00 wrap with a couple of drives of cnt_i.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

   localparam int unsigned MODE_W = 7;

   // Packed so that bit 0 is the interrupt enable and bit 6 the comparator enable.
   typedef struct packed {
      logic cmp;
      logic rise;
      logic fall;
      logic mat;
      logic tog;
      logic pwm;
      logic irq;
   } mode_t;

endpackage

// File: rtl/ccp_edge_sync.sv
module ccp_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ccp_edge_sync: STAGES must be at least 2");
   end

   // chain[STAGES-1] is the synchronized sample, chain[STAGES] the one before it.
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= pin_i;
   end

   for (genvar k = 1; k <= STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[k] <= 1'b0;
         else        chain[k] <= chain[k-1];
      end
   end

   assign rise_o = chain[STAGES-1] & ~chain[STAGES];
   assign fall_o = ~chain[STAGES-1] & chain[STAGES];

   // An edge seen now must have been the synchronized level one cycle later.
   assert_edge_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> chain[STAGES]);

endmodule

// File: rtl/ccp_cc_reg.sv
module ccp_cc_reg #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cap_i,
   input  logic [2*BYTE_W-1:0]   cap_val_i,
   input  logic                  lo_we_i,
   input  logic                  hi_we_i,
   input  logic [BYTE_W-1:0]     wdata_i,
   input  logic                  reload_i,
   output logic [2*BYTE_W-1:0]   q_o
);

   localparam int unsigned CNT_W = 2 * BYTE_W;

   logic [BYTE_W-1:0] lo_q, hi_q;
   logic [BYTE_W-1:0] lo_d, hi_d;

   always_comb begin
      lo_d = lo_q;
      hi_d = hi_q;
      if (cap_i) begin
         lo_d = cap_val_i[BYTE_W-1:0];
         hi_d = cap_val_i[CNT_W-1:BYTE_W];
      end else begin
         if (lo_we_i)       lo_d = wdata_i;
         else if (reload_i) lo_d = hi_q;
         if (hi_we_i)       hi_d = wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_d;
         hi_q <= hi_d;
      end
   end

   assign q_o = {hi_q, lo_q};

   assert_capture_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_i && (lo_we_i || hi_we_i)) |=> (q_o == $past(cap_val_i)));

   assert_reload_copies_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_i && !cap_i && !lo_we_i && !hi_we_i) |=>
         (q_o[BYTE_W-1:0] == $past(q_o[CNT_W-1:BYTE_W])));

endmodule

// File: rtl/ccp_compare.sv
module ccp_compare #(
   parameter int unsigned BYTE_W    = 8,
   parameter logic        PIN_RESET = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2*BYTE_W-1:0]   cnt_i,
   input  logic [2*BYTE_W-1:0]   cc_i,
   input  logic                  cmp_en_i,
   input  logic                  tog_en_i,
   input  logic                  pwm_en_i,
   output logic                  match_o,
   output logic                  wrap_o,
   output logic                  pin_o
);

   localparam int unsigned CNT_W = 2 * BYTE_W;

   logic              eq, eq_q;
   logic              pwm_act;
   logic [BYTE_W-1:0] cnt_lo, cc_lo, prev_lo;
   logic              pin_q;

   assign cnt_lo  = cnt_i[BYTE_W-1:0];
   assign cc_lo   = cc_i[BYTE_W-1:0];
   assign pwm_act = cmp_en_i & pwm_en_i;
   assign eq      = cmp_en_i && (cnt_i == cc_i);
   assign match_o = eq & ~eq_q;
   assign wrap_o  = pwm_act && (prev_lo == {BYTE_W{1'b1}}) && (cnt_lo == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eq_q    <= 1'b0;
         prev_lo <= '0;
         pin_q   <= PIN_RESET;
      end else begin
         eq_q    <= eq;
         prev_lo <= cnt_lo;
         if (pwm_act)                 pin_q <= (cnt_lo >= cc_lo);
         else if (match_o && tog_en_i) pin_q <= ~pin_q;
      end
   end

   assign pin_o = pin_q;

   assert_toggle_flips_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && tog_en_i && !pwm_en_i) |=> (pin_o != $past(pin_o)));

   assert_cmp_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_en_i |=> $stable(pin_o));

   assert_pwm_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en_i && pwm_en_i) |=>
         (pin_o == ($past(cnt_i[BYTE_W-1:0]) >= $past(cc_i[BYTE_W-1:0]))));

   assert_match_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |=> !match_o);

   if (CNT_W != 2 * BYTE_W) begin : g_bad_width
      $error("ccp_compare: count width must be two bytes");
   end

endmodule

// File: rtl/ccp_channel.sv
module ccp_channel #(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic        PIN_RESET   = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [2*BYTE_W-1:0]     cnt_i,
   input  logic                    pin_i,
   input  logic                    mode_we_i,
   input  logic [6:0]              mode_wdata_i,
   input  logic                    cc_lo_we_i,
   input  logic                    cc_hi_we_i,
   input  logic [BYTE_W-1:0]       cc_wdata_i,
   output logic [2*BYTE_W-1:0]     cc_o,
   output logic                    flag_set_o,
   output logic                    irq_en_o,
   output logic                    pin_o
);

   import ccp_pkg::*;

   localparam int unsigned CNT_W = 2 * BYTE_W;

   if (BYTE_W < 2) begin : g_bad_byte
      $error("ccp_channel: BYTE_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ccp_channel: SYNC_STAGES must be at least 2");
   end
   if ($bits(mode_t) != MODE_W) begin : g_bad_mode
      $error("ccp_channel: mode word width mismatch");
   end

   mode_t mode_q;
   logic  rise, fall, cap;
   logic  match, wrap;
   logic  flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mode_q <= '0;
      else if (mode_we_i) mode_q <= mode_t'(mode_wdata_i);
   end

   ccp_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i),
      .rise_o (rise),
      .fall_o (fall)
   );

   assign cap = (rise & mode_q.rise) | (fall & mode_q.fall);

   ccp_cc_reg #(.BYTE_W(BYTE_W)) i_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_i     (cap),
      .cap_val_i (cnt_i),
      .lo_we_i   (cc_lo_we_i),
      .hi_we_i   (cc_hi_we_i),
      .wdata_i   (cc_wdata_i),
      .reload_i  (wrap),
      .q_o       (cc_o)
   );

   ccp_compare #(.BYTE_W(BYTE_W), .PIN_RESET(PIN_RESET)) i_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_i    (cnt_i),
      .cc_i     (cc_o),
      .cmp_en_i (mode_q.cmp),
      .tog_en_i (mode_q.tog),
      .pwm_en_i (mode_q.pwm),
      .match_o  (match),
      .wrap_o   (wrap),
      .pin_o    (pin_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= cap | (match & mode_q.mat);
   end

   assign flag_set_o = flag_q;
   assign irq_en_o   = mode_q.irq;

   assert_capture_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (cc_o == $past(cnt_i) && flag_set_o));

   assert_irq_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_we_i |=> (irq_en_o == $past(mode_wdata_i[0])));

   assert_no_flag_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap && !mode_q.cmp) |=> !flag_set_o);

   if (CNT_W != 16 && CNT_W < 4) begin : g_bad_cnt
      $error("ccp_channel: count too narrow");
   end

endmodule

// File: tb/test_ccp_channel.sv
`timescale 1ns/1ps
module test_ccp_channel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt_i = '0;
   logic        pin_i = 1'b0;
   logic        mode_we_i = 1'b0;
   logic [6:0]  mode_wdata_i = '0;
   logic        cc_lo_we_i = 1'b0;
   logic        cc_hi_we_i = 1'b0;
   logic [7:0]  cc_wdata_i = '0;
   logic [15:0] cc_o;
   logic        flag_set_o, irq_en_o, pin_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   localparam logic [6:0] M_IRQ = 7'h01, M_PWM = 7'h02, M_TOG = 7'h04, M_MAT = 7'h08,
                          M_FALL = 7'h10, M_RISE = 7'h20, M_CMP = 7'h40;

   always #10 clk = ~clk;

   ccp_channel i_ccp_channel (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .pin_i(pin_i),
      .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i),
      .cc_lo_we_i(cc_lo_we_i), .cc_hi_we_i(cc_hi_we_i), .cc_wdata_i(cc_wdata_i),
      .cc_o(cc_o), .flag_set_o(flag_set_o), .irq_en_o(irq_en_o), .pin_o(pin_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_mode(input logic [6:0] m);
      @(negedge clk); mode_we_i = 1'b1; mode_wdata_i = m;
      @(negedge clk); mode_we_i = 1'b0;
   endtask

   task automatic wr_cc(input logic [15:0] v);
      @(negedge clk); cc_lo_we_i = 1'b1; cc_wdata_i = v[7:0];
      @(negedge clk); cc_lo_we_i = 1'b0; cc_hi_we_i = 1'b1; cc_wdata_i = v[15:8];
      @(negedge clk); cc_hi_we_i = 1'b0;
   endtask

   // Changes the pin, then watches four cycles; returns the flag pulses seen.
   task automatic pin_edge(input logic lvl, output int flags);
      flags = 0;
      @(negedge clk); pin_i = lvl;
      repeat (4) begin
         @(negedge clk);
         if (flag_set_o) flags++;
      end
   endtask

   task automatic t_reset;
      check(cc_o == 16'h0, "R1 cc_o", cc_o, 0);
      check(pin_o == 1'b0, "R1 pin_o", pin_o, 0);
      check(flag_set_o == 1'b0, "R1 flag", flag_set_o, 0);
      check(irq_en_o == 1'b0, "R1 irq_en", irq_en_o, 0);
   endtask

   task automatic t_irq;
      wr_mode(M_IRQ);
      check(irq_en_o == 1'b1, "R2 irq set", irq_en_o, 1);
      wr_mode(7'h00);
      check(irq_en_o == 1'b0, "R2 irq clear", irq_en_o, 0);
   endtask

   task automatic t_write;
      @(negedge clk); cc_lo_we_i = 1'b1; cc_wdata_i = 8'h3C;
      @(negedge clk); cc_lo_we_i = 1'b0;
      check(cc_o == 16'h003C, "R3 low byte", cc_o, 16'h003C);
      @(negedge clk); cc_hi_we_i = 1'b1; cc_wdata_i = 8'hA7;
      @(negedge clk); cc_hi_we_i = 1'b0;
      check(cc_o == 16'hA73C, "R3 high byte", cc_o, 16'hA73C);
   endtask

   task automatic t_cap_rise;
      int f;
      wr_mode(M_RISE);
      cnt_i = 16'h1357;
      pin_edge(1'b1, f);
      check(cc_o == 16'h1357, "R4 rise capture value", cc_o, 16'h1357);
      check(f == 1, "R4 one flag pulse", f, 1);
      // precise latency: third edge after the change
      @(negedge clk); pin_i = 1'b0;
      @(negedge clk); pin_i = 1'b1; cnt_i = 16'h2468;
      @(negedge clk);
      @(negedge clk);
      check(cc_o == 16'h1357 && !flag_set_o, "R4 not before third edge", cc_o, 16'h1357);
      @(negedge clk);
      check(cc_o == 16'h2468 && flag_set_o, "R4 at third edge", cc_o, 16'h2468);
   endtask

   task automatic t_cap_fall_both;
      int f;
      wr_mode(M_FALL);
      cnt_i = 16'h0F0F;
      pin_edge(1'b0, f);
      check(cc_o == 16'h0F0F && f == 1, "R5 falling capture", cc_o, 16'h0F0F);
      cnt_i = 16'h7777;
      pin_edge(1'b1, f);
      check(cc_o == 16'h0F0F, "R5 rise ignored value", cc_o, 16'h0F0F);
      check(f == 0, "R5 rise ignored flag", f, 0);
      wr_mode(M_FALL | M_RISE);
      cnt_i = 16'h4444;
      pin_edge(1'b0, f);
      check(cc_o == 16'h4444 && f == 1, "R5 both fall", cc_o, 16'h4444);
      cnt_i = 16'h5555;
      pin_edge(1'b1, f);
      check(cc_o == 16'h5555 && f == 1, "R5 both rise", cc_o, 16'h5555);
   endtask

   task automatic t_match;
      int f;
      wr_mode(7'h00);
      cnt_i = 16'h0000;
      wr_cc(16'h1234);
      wr_mode(M_CMP | M_MAT);
      @(negedge clk); cnt_i = 16'h1234;
      @(negedge clk);
      check(flag_set_o == 1'b1, "R6 match pulse", flag_set_o, 1);
      f = 0;
      repeat (4) begin @(negedge clk); if (flag_set_o) f++; end
      check(f == 0, "R6 no repeat while held", f, 0);
      cnt_i = 16'h1235;
      @(negedge clk); cnt_i = 16'h1234;
      @(negedge clk);
      check(flag_set_o == 1'b1, "R6 second match", flag_set_o, 1);
   endtask

   task automatic t_toggle;
      logic p0;
      cnt_i = 16'h0000;
      wr_mode(M_CMP | M_TOG);
      p0 = pin_o;
      @(negedge clk); cnt_i = 16'h1234;
      @(negedge clk);
      check(pin_o == ~p0, "R7 toggle first", pin_o, ~p0);
      repeat (3) @(negedge clk);
      check(pin_o == ~p0, "R7 held no retoggle", pin_o, ~p0);
      cnt_i = 16'h0001;
      @(negedge clk); cnt_i = 16'h1234;
      @(negedge clk);
      check(pin_o == p0, "R7 toggle back", pin_o, p0);
   endtask

   task automatic t_cmp_off;
      logic p0;
      int f;
      cnt_i = 16'h0000;
      wr_mode(M_TOG | M_MAT);
      p0 = pin_o;
      f = 0;
      @(negedge clk); cnt_i = 16'h1234;
      repeat (3) begin @(negedge clk); if (flag_set_o) f++; end
      check(f == 0, "R8 no flag", f, 0);
      check(pin_o == p0, "R8 pin stable", pin_o, p0);
   endtask

   task automatic t_pwm;
      wr_mode(7'h00);
      wr_cc(16'h8040);
      wr_mode(M_CMP | M_PWM);
      @(negedge clk); cnt_i = 16'h0030;
      @(negedge clk);
      check(pin_o == 1'b0, "R9 below compare low", pin_o, 0);
      cnt_i = 16'h0040;
      @(negedge clk);
      check(pin_o == 1'b1, "R9 equal high", pin_o, 1);
      cnt_i = 16'h00F0;
      @(negedge clk);
      check(pin_o == 1'b1, "R9 above high", pin_o, 1);
   endtask

   task automatic t_reload;
      cnt_i = 16'h00FF;
      @(negedge clk);
      check(cc_o == 16'h8040, "R10 no reload before wrap", cc_o, 16'h8040);
      cnt_i = 16'h0100;
      @(negedge clk);
      check(cc_o == 16'h8080, "R10 reload on wrap", cc_o, 16'h8080);
      cnt_i = 16'h0170;
      @(negedge clk);
      check(pin_o == 1'b0, "R10 new duty applied", pin_o, 0);
   endtask

   task automatic t_override;
      wr_mode(7'h00);
      @(negedge clk); pin_i = 1'b0;
      repeat (3) @(negedge clk);
      wr_mode(M_RISE);
      cnt_i = 16'h5A5A;
      @(negedge clk); pin_i = 1'b1;
      @(negedge clk);
      @(negedge clk); cc_lo_we_i = 1'b1; cc_hi_we_i = 1'b1; cc_wdata_i = 8'hAA;
      @(negedge clk); cc_lo_we_i = 1'b0; cc_hi_we_i = 1'b0;
      check(cc_o == 16'h5A5A, "R11 capture beats write", cc_o, 16'h5A5A);
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_irq;
      t_write;
      t_cap_rise;
      t_cap_fall_both;
      t_match;
      t_toggle;
      t_cmp_off;
      t_pwm;
      t_reload;
      t_override;
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule